// File: doc/BRIEF.md
# Loudest-Talker Conference Selector

This block sits in the sample path of a three-party audio conference and picks one speaker to hear. Every participant channel delivers 16-bit two's-complement samples together; a shared valid marks each sample slot and a frame-start strobe marks the first slot of each 64-sample frame. Over each frame the block sums the magnitudes of every channel's samples, and the channel with the largest sum wins that frame.

Each channel keeps a count of the frames it has won. The active talker changes only when one channel's count reaches a programmable threshold. All counts then restart from zero. This hysteresis stops a short burst of noise or a cough from taking the conference away from the current speaker. The chosen input is copied onto all three outputs, one cycle after the sample is accepted. A new choice takes effect from the first sample of the following frame, so a frame is never split between two talkers.

Top module: `loud_talker_sel`

## Requirements
- R1: After a synchronous active-low reset, `sel_ch` is 0, `out_vld` is 0 and all three outputs are 0.
- R2: A frame starts with a valid slot that has `frame_start` high and ends at its 64th valid slot. A channel's frame energy is the sum of the magnitudes of its 64 samples, held without wrap, and the channel with the largest energy wins the frame.
- R3: The magnitude of the most negative sample (0x8000) counts as 32767, the same as 0x7FFF.
- R4: When energies are equal, the lowest-numbered channel among the largest wins.
- R5: The winner's win count rises by one per completed frame. Counts of the other channels are kept unchanged across frames they lose.
- R6: When the winner's count reaches the threshold, that channel becomes the pending selection and all three counts return to zero.
- R7: The threshold comes from the 8-bit `thresh` input. A count is limited to the threshold, so a winner switches as soon as its incremented count is at least the threshold. Values 0 and 1 both switch on a single win, and lowering the threshold below a held count switches on that channel's next win.
- R8: Every valid slot produces, one cycle later, `out_vld` high with all three outputs equal to the input sample of the channel selected for that slot.
- R9: A pending selection takes effect from the slot carrying the next `frame_start`, including that slot's output. `sel_ch` changes at the same time and at no other time.
- R10: A frame cut short by a new `frame_start` before its 64th slot yields no decision. Valid slots outside any frame are routed but do not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample slot valid for all channels |
| frame_start | input | 1 | Marks the first slot of a frame (qualified by smp_vld) |
| thresh | input | 8 | Number of frame wins needed to switch talker |
| smp_in | input | 3x16 | Channel input samples, element c is channel c |
| smp_out | output | 3x16 | Routed outputs, all carry the selected channel's sample |
| out_vld | output | 1 | Outputs valid, one cycle after smp_vld |
| sel_ch | output | 2 | Channel currently routed to the outputs |

## Verification
On every cycle the assertions confirm that accumulators never wrap, that the frame position stays inside the frame, that counts move only on a completed frame and all clear after a switch, that the active selection moves only at a frame start, and that output valid follows input valid by one cycle. Which channel wins a frame, tie order, the treatment of 0x8000, and the number of wins needed under different thresholds can only be shown by the bench. Its reference model replays interleaved win histories, ties, a threshold lowered below a held count, and a frame cut short by a new frame start. It then compares every routed sample and the talker index against that model.

// File: rtl/lts_pkg.sv
// Shared defaults and types for the loudest-talker selector.
// Assumes all channels share one sample clock domain and one valid.
package lts_pkg;
    localparam int DEF_NUM_CH = 3;
    localparam int DEF_SMP_W  = 16;
    localparam int DEF_FRAME  = 64;
    localparam int DEF_THR_W  = 8;

    typedef enum logic [0:0] {
        FR_IDLE = 1'b0,
        FR_BUSY = 1'b1
    } fr_state_e;
endpackage

// File: rtl/lts_frame_ctrl.sv
// Frame position tracker.
// Decodes which valid slots belong to a frame and flags the last one.
// Assumes FRAME_LEN >= 2; a new frame_start restarts the count at any time.
module lts_frame_ctrl
    import lts_pkg::*;
#(
    parameter int FRAME_LEN = DEF_FRAME
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic frame_start,
    output logic first_slot,
    output logic take_slot,
    output logic frame_done
);
    localparam int IDX_W = $clog2(FRAME_LEN + 1);

    fr_state_e        state;
    logic [IDX_W-1:0] idx;

    // Slot classification for the current cycle.
    always_comb begin
        first_slot = smp_vld && frame_start;
        take_slot  = smp_vld && (frame_start || state == FR_BUSY);
        frame_done = take_slot && !first_slot && (idx == IDX_W'(FRAME_LEN - 1));
    end

    // Slot counter and in-frame flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FR_IDLE;
            idx   <= '0;
        end else if (take_slot) begin
            if (frame_done) begin
                state <= FR_IDLE;
                idx   <= '0;
            end else begin
                state <= FR_BUSY;
                idx   <= first_slot ? IDX_W'(1) : idx + 1'b1;
            end
        end
    end

    assert_idx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_BUSY) |-> (idx >= IDX_W'(1) && idx <= IDX_W'(FRAME_LEN - 1)));
    assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_IDLE) |-> (idx == '0));
endmodule

// File: rtl/lts_energy_acc.sv
// Per-channel frame energy accumulator (sum of sample magnitudes).
// Exposes the running sum including the present slot, so the final
// energy is available in the same cycle as the last slot of the frame.
// Assumes ACC_W is wide enough for FRAME_LEN full-scale magnitudes.
module lts_energy_acc #(
    parameter int SMP_W = 16,
    parameter int ACC_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_slot,
    input  logic             take_slot,
    input  logic [SMP_W-1:0] smp,
    output logic [ACC_W-1:0] energy_now
);
    logic [ACC_W-1:0] acc;
    logic [SMP_W-1:0] neg_s;
    logic [SMP_W-2:0] mag;
    logic [ACC_W-1:0] base;

    assign neg_s = -smp;

    // Saturating magnitude: the most negative code maps to full positive scale.
    always_comb begin
        if (smp == {1'b1, {(SMP_W-1){1'b0}}})
            mag = '1;
        else if (smp[SMP_W-1])
            mag = neg_s[SMP_W-2:0];
        else
            mag = smp[SMP_W-2:0];
    end

    // Sum including the current slot; restarts on the first slot.
    always_comb begin
        base       = first_slot ? '0 : acc;
        energy_now = base + ACC_W'(mag);
    end

    // Running accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (take_slot)
            acc <= energy_now;
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_slot && !first_slot) |-> (energy_now >= acc));
endmodule

// File: rtl/lts_hyst_select.sv
// Frame winner detection and hysteresis talker selection.
// Picks the largest energy (lowest index on ties), counts wins per channel,
// and arms a pending choice when a count reaches the threshold. The pending
// choice becomes active on the next frame-start slot.
module lts_hyst_select #(
    parameter int NUM_CH = 3,
    parameter int ACC_W  = 23,
    parameter int THR_W  = 8,
    parameter int SEL_W  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_done,
    input  logic                         apply_slot,
    input  logic [NUM_CH-1:0][ACC_W-1:0] energy,
    input  logic [THR_W-1:0]             thresh,
    output logic [SEL_W-1:0]             active_sel,
    output logic [SEL_W-1:0]             route_sel
);
    logic [THR_W-1:0] win_cnt [NUM_CH];
    logic [SEL_W-1:0] best;
    logic [ACC_W-1:0] best_e;
    logic [THR_W-1:0] cnt_best;
    logic [THR_W:0]   bump;
    logic             hit;
    logic [THR_W-1:0] sat;
    logic             switch_now;
    logic [SEL_W-1:0] pend_sel;

    // Arg-max over channel energies; strict compare keeps the lowest index on ties.
    always_comb begin
        best     = '0;
        best_e   = energy[0];
        cnt_best = win_cnt[0];
        for (int i = 1; i < NUM_CH; i++) begin
            if (energy[i] > best_e) begin
                best     = SEL_W'(i);
                best_e   = energy[i];
                cnt_best = win_cnt[i];
            end
        end
    end

    // Winner count step, limited to the threshold.
    always_comb begin
        bump       = {1'b0, cnt_best} + 1'b1;
        hit        = bump >= {1'b0, thresh};
        sat        = hit ? thresh : bump[THR_W-1:0];
        switch_now = frame_done && hit;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
        // Win counter of one channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                win_cnt[c] <= '0;
            else if (switch_now)
                win_cnt[c] <= '0;
            else if (frame_done && best == SEL_W'(c))
                win_cnt[c] <= sat;
        end

        assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            switch_now |=> (win_cnt[c] == '0));
        assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_done |=> $stable(win_cnt[c]));
    end

    // Pending talker, armed when a count reaches the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_sel <= '0;
        else if (switch_now)
            pend_sel <= best;
    end

    // Active talker, updated only on a frame-start slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_sel <= '0;
        else if (apply_slot)
            active_sel <= pend_sel;
    end

    assign route_sel = apply_slot ? pend_sel : active_sel;

    assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_slot |=> $stable(active_sel));
    assert_sel_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active_sel < SEL_W'(NUM_CH));
endmodule

// File: rtl/loud_talker_sel.sv
// Loudest-talker conference selector, top level.
// Measures per-frame energy of each channel, applies win-count hysteresis,
// and copies the selected channel onto every output one cycle later.
// Assumes all channels share smp_vld and frame_start.
module loud_talker_sel
    import lts_pkg::*;
#(
    parameter int NUM_CH    = DEF_NUM_CH,
    parameter int SMP_W     = DEF_SMP_W,
    parameter int FRAME_LEN = DEF_FRAME,
    parameter int THR_W     = DEF_THR_W,
    parameter int SEL_W     = $clog2(NUM_CH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_vld,
    input  logic                         frame_start,
    input  logic [THR_W-1:0]             thresh,
    input  logic [NUM_CH-1:0][SMP_W-1:0] smp_in,
    output logic [NUM_CH-1:0][SMP_W-1:0] smp_out,
    output logic                         out_vld,
    output logic [SEL_W-1:0]             sel_ch
);
    localparam int ACC_W = SMP_W + $clog2(FRAME_LEN) + 1;

    logic                         first_slot;
    logic                         take_slot;
    logic                         frame_done;
    logic [NUM_CH-1:0][ACC_W-1:0] ch_energy;
    logic [SEL_W-1:0]             route_sel;
    logic [SEL_W-1:0]             active_sel;
    logic [SMP_W-1:0]             routed;

    lts_frame_ctrl #(.FRAME_LEN(FRAME_LEN)) frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld     (smp_vld),
        .frame_start (frame_start),
        .first_slot  (first_slot),
        .take_slot   (take_slot),
        .frame_done  (frame_done)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_acc
        lts_energy_acc #(.SMP_W(SMP_W), .ACC_W(ACC_W)) acc_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .first_slot (first_slot),
            .take_slot  (take_slot),
            .smp        (smp_in[c]),
            .energy_now (ch_energy[c])
        );
    end

    lts_hyst_select #(
        .NUM_CH (NUM_CH),
        .ACC_W  (ACC_W),
        .THR_W  (THR_W),
        .SEL_W  (SEL_W)
    ) sel_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .apply_slot (first_slot),
        .energy     (ch_energy),
        .thresh     (thresh),
        .active_sel (active_sel),
        .route_sel  (route_sel)
    );

    // Output register: selected sample and its valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            routed  <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= smp_vld;
            if (smp_vld)
                routed <= smp_in[route_sel];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_out
        assign smp_out[c] = routed;
    end

    assign sel_ch = active_sel;

    assert_out_vld_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> out_vld);
    assert_out_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !out_vld);
endmodule

// File: tb/loud_talker_sel_tb_top.sv
// Scoreboard bench: the driver pushes expected routed samples computed by a
// requirement-level model; a monitor pops and compares them as outputs appear.
module loud_talker_sel_tb_top;
    localparam int NCH   = 3;
    localparam int FRAME = 64;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    smp_vld = 1'b0;
    logic                    frame_start = 1'b0;
    logic [7:0]              thresh = 8'd4;
    logic [NCH-1:0][15:0]    smp_in = '0;
    logic [NCH-1:0][15:0]    smp_out;
    logic                    out_vld;
    logic [1:0]              sel_ch;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] v;
        logic [1:0]  s;
    } exp_t;
    exp_t exp_q[$];

    // Requirement model state
    int m_cnt [NCH];
    int m_pend = 0;
    int m_act  = 0;
    longint m_e [NCH];

    always #10 clk = ~clk;

    loud_talker_sel dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld     (smp_vld),
        .frame_start (frame_start),
        .thresh      (thresh),
        .smp_in      (smp_in),
        .smp_out     (smp_out),
        .out_vld     (out_vld),
        .sel_ch      (sel_ch)
    );

    function automatic int mag_of(logic [15:0] x);
        int v;
        v = int'($signed(x));
        if (v == -32768) return 32767;
        return (v < 0) ? -v : v;
    endfunction

    function automatic logic [15:0] smp_of(int a, int k);
        if (a == -32768) return 16'h8000;
        return 16'((k % 2 == 1) ? -a : a);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Model decision at a completed frame (R2, R4, R5, R6, R7)
    task automatic model_decide();
        int best;
        int bump;
        best = 0;
        for (int c = 1; c < NCH; c++) if (m_e[c] > m_e[best]) best = c;
        bump = m_cnt[best] + 1;
        if (bump >= int'(thresh)) begin
            m_pend = best;
            for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
        end else begin
            m_cnt[best] = bump;
        end
    endtask

    // Drives one frame of len slots (full frame when len == FRAME), then gap idle cycles.
    task automatic run_frame(input int a0, input int a1, input int a2, input int len, input int gap);
        int amp [NCH];
        exp_t e;
        amp[0] = a0; amp[1] = a1; amp[2] = a2;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            smp_vld     = 1'b1;
            frame_start = (k == 0);
            for (int c = 0; c < NCH; c++) smp_in[c] = smp_of(amp[c], k);
            if (k == 0) begin
                m_act = m_pend;
                for (int c = 0; c < NCH; c++) m_e[c] = 0;
            end
            for (int c = 0; c < NCH; c++) m_e[c] += mag_of(smp_of(amp[c], k));
            e.v = smp_of(amp[m_act], k);
            e.s = 2'(m_act);
            exp_q.push_back(e);
            if (k == FRAME - 1) model_decide();
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            smp_vld     = 1'b0;
            frame_start = 1'b0;
        end
    endtask

    // Valid slots outside any frame: routed, never counted (R10)
    task automatic run_stray(input int a0, input int a1, input int a2, input int n);
        int amp [NCH];
        exp_t e;
        amp[0] = a0; amp[1] = a1; amp[2] = a2;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            smp_vld     = 1'b1;
            frame_start = 1'b0;
            for (int c = 0; c < NCH; c++) smp_in[c] = smp_of(amp[c], k + 3);
            e.v = smp_of(amp[m_act], k + 3);
            e.s = 2'(m_act);
            exp_q.push_back(e);
        end
        @(negedge clk);
        smp_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_sel(input int expv, input string req);
        @(negedge clk);
        check(sel_ch == 2'(expv), req, int'(sel_ch), expv);
    endtask

    // Monitor: compare every routed slot against the scoreboard (R8, R9)
    always @(negedge clk) begin
        if (rst_n && out_vld && !finished) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                for (int c = 0; c < NCH; c++)
                    check(smp_out[c] == e.v, "R8 routed sample", int'(smp_out[c]), int'(e.v));
                check(sel_ch == e.s, "R9 talker at slot", int'(sel_ch), int'(e.s));
            end
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sel_ch == 2'd0, "R1 sel_ch", int'(sel_ch), 0);
        check(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
        check(smp_out == '0, "R1 outputs", int'(smp_out[0]), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: stray slots before any frame are routed but not counted
        run_stray(10, 9000, 20, 20);
        // R5: channel 1 wins three frames, no switch yet at threshold 4
        run_frame(100, 2000, 50, FRAME, 2);
        run_frame(100, 2000, 50, FRAME, 2);
        run_frame(100, 2000, 50, FRAME, 2);
        chk_sel(0, "R5 three wins below threshold");
        // R6: fourth win arms channel 1; R9: not active until next frame start
        run_frame(100, 2000, 50, FRAME, 2);
        chk_sel(0, "R9 pending not applied before frame start");
        run_frame(3000, 10, 10, FRAME, 2);
        chk_sel(1, "R6 switch after threshold wins");

        // R5: interleaved wins persist; channel 0 reaches four first
        run_frame(10, 10, 5000, FRAME, 0);
        run_frame(10, 10, 5000, FRAME, 0);
        run_frame(10, 10, 5000, FRAME, 0);
        run_frame(4000, 10, 10, FRAME, 0);
        run_frame(4000, 10, 10, FRAME, 0);
        run_frame(4000, 10, 10, FRAME, 2);
        run_frame(10, 10, 10, FRAME, 2);
        chk_sel(0, "R5 counts kept across lost frames");
        // R6: channel 2 held three wins, but counts were cleared on the switch
        run_frame(10, 10, 5000, FRAME, 2);
        run_frame(10, 10, 10, FRAME, 2);
        chk_sel(0, "R6 counts cleared on switch");

        // R4: tie between channels 1 and 2 goes to channel 1
        run_frame(5, 700, 700, FRAME, 0);
        run_frame(5, 700, 700, FRAME, 0);
        run_frame(5, 700, 700, FRAME, 0);
        run_frame(5, 700, 700, FRAME, 2);
        run_frame(0, 0, 0, FRAME, 2);
        chk_sel(1, "R4 tie resolves to lower index");

        // R3: 0x8000 counts as 32767, ties with 0x7FFF, lower index wins (threshold 1)
        thresh = 8'd1;
        run_frame(0, 32767, -32768, FRAME, 2);
        run_frame(0, 0, 0, FRAME, 2);
        chk_sel(1, "R3 saturated magnitude of 0x8000");
        // R7: threshold 1 switches on a single win
        run_frame(0, 0, 900, FRAME, 2);
        run_frame(0, 0, 0, FRAME, 2);
        chk_sel(2, "R7 threshold one");
        // R7: threshold 0 behaves like 1
        thresh = 8'd0;
        run_frame(900, 0, 0, FRAME, 2);
        run_frame(0, 0, 0, FRAME, 2);
        chk_sel(0, "R7 threshold zero");

        // R7: lowering the threshold below a held count switches on the next win
        thresh = 8'd4;
        run_frame(1, 800, 1, FRAME, 0);
        run_frame(1, 800, 1, FRAME, 0);
        run_frame(1, 800, 1, FRAME, 2);
        thresh = 8'd2;
        run_frame(1, 800, 1, FRAME, 2);
        run_frame(0, 0, 0, FRAME, 2);
        chk_sel(1, "R7 lowered threshold");

        // R10: a short frame must not count as a win
        thresh = 8'd4;
        run_frame(1, 1, 6000, FRAME, 0);
        run_frame(1, 1, 6000, FRAME, 0);
        run_frame(1, 1, 6000, FRAME, 0);
        run_frame(1, 1, 6000, 30, 0);
        run_frame(2000, 1, 1, FRAME, 2);
        run_stray(1, 1, 6000, 10);
        run_frame(0, 0, 0, FRAME, 2);
        chk_sel(1, "R10 short frame ignored");
        // R2: the fourth full win of channel 2 now switches
        run_frame(1, 1, 6000, FRAME, 2);
        run_frame(0, 0, 0, FRAME, 2);
        chk_sel(2, "R2 full frame energy decides");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8 all slots produced", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule